// File: doc/BRIEF.md
# Cold Reset Sequence Generator

This block runs a processor's cold-reset handshake from one reference clock. While the start request (power rails stable) is low it holds the processor in reset and drives the 5-bit bus-ratio code, which selects the system bus frequency. When the request rises, the block freezes the ratio code and a vector of extra configuration values. It then raises the power-good output, waits a long interval, drives the extra configuration, and releases reset on a clock edge. A few clocks after release it stops driving the configuration pins and raises a done flag.

Every interval is a parameter counted in reference-clock cycles. The long interval is sized so that it covers at least one millisecond at the reference clock frequency. If the start request drops at any point, the block returns to idle with reset asserted and power-good low. It restarts the full sequence when the request returns.

Top module: `cold_reset_seq`

## Requirements
- R1: After the synchronous reset, `prst_n_o` is 0, `pwr_ok_o` is 0, `xcfg_oe_o` is 0, `seq_done_o` is 0 and `ratio_oe_o` is 1.
- R2: `ratio_oe_o` is 1 in every cycle in which `prst_n_o` is 0. From the clock that samples `start_i` high in idle, `ratio_o` holds the `ratio_i` value sampled on that clock.
- R3: `pwr_ok_o` rises LEAD_CYC+1 clocks after the clock that samples `start_i` high in idle, and `prst_n_o` is still 0 when it rises.
- R4: `prst_n_o` rises exactly WAIT_CYC clocks after `pwr_ok_o` rises.
- R5: `xcfg_oe_o` rises exactly PRE_CYC clocks before `prst_n_o` rises. From then on, `xcfg_o` equals the `xcfg_i` value sampled on the start clock.
- R6: `ratio_oe_o` and `xcfg_oe_o` fall exactly HOLD_CYC (2 or 3) clocks after `prst_n_o` rises. `seq_done_o` rises on that same clock.
- R7: Changes on `ratio_i` or `xcfg_i` after the start clock have no effect on `ratio_o` or `xcfg_o` until the block is back in idle.
- R8: If `start_i` is low on a clock while the sequence runs, then after that clock `prst_n_o`, `pwr_ok_o`, `xcfg_oe_o` and `seq_done_o` are all 0. A later start runs the whole sequence again with freshly sampled values.
- R9: `seq_done_o`, `prst_n_o` and `pwr_ok_o` stay 1 for as long as `start_i` stays high after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| start_i | input | 1 | Start request; level-sensitive, low aborts |
| ratio_i | input | RATIO_W | Bus-ratio code to present |
| xcfg_i | input | XCFG_W | Extra configuration values |
| prst_n_o | output | 1 | Active-low processor reset |
| pwr_ok_o | output | 1 | Power-good indication to processor |
| ratio_o | output | RATIO_W | Captured bus-ratio code |
| ratio_oe_o | output | 1 | Output-enable for the ratio pins |
| xcfg_o | output | XCFG_W | Captured extra configuration |
| xcfg_oe_o | output | 1 | Output-enable for the extra configuration pins |
| seq_done_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with WAIT_CYC=20, LEAD_CYC=2, PRE_CYC=4, HOLD_CYC=3 and an 8-bit configuration vector. With a 20-clock interval, a whole cold-reset run fits in a few dozen cycles. Each edge (power-good, configuration enable, reset release, enable drop) can then be located at its exact clock and compared with the parameter formulas. The short interval also lets the bench abort in the middle of the wait and restart with new values, which a millisecond-scale default would put out of reach.

// File: rtl/cold_rst_pkg.sv
// Shared state encoding for the cold reset sequencer.
// Assumes: used by seq_fsm and the top only.
package cold_rst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ASSERT    = 3'd1,
        ST_PWR_ON    = 3'd2,
        ST_WAIT      = 3'd3,
        ST_PRE_REL   = 3'd4,
        ST_REL_HOLD  = 3'd5,
        ST_DONE      = 3'd6
    } seq_state_t;
endpackage

// File: rtl/seq_timer.sv
// Down counter for state durations. A load sets the count; otherwise the
// count decrements and saturates at zero.
// Assumes: load_val fits CNT_W bits.
module seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load or count down, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));
endmodule

// File: rtl/cfg_capture.sv
// Holds the ratio code and extra configuration. Both follow their inputs
// while capture_en is high (idle) and freeze when it drops.
// Assumes: capture_en is high only in the idle state.
module cfg_capture #(
    parameter int RATIO_W = 5,
    parameter int XCFG_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_en,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [XCFG_W-1:0]  xcfg_i,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [XCFG_W-1:0]  xcfg_q
);
    // Track inputs in idle, hold them during the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= '0;
            xcfg_q  <= '0;
        end else if (capture_en) begin
            ratio_q <= ratio_i;
            xcfg_q  <= xcfg_i;
        end
    end

    // R7
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(capture_en)) |-> ($stable(ratio_q) && $stable(xcfg_q)));
endmodule

// File: rtl/seq_fsm.sv
// Sequencing state machine. Each timed state loads the timer on entry with
// its length minus one and leaves when the timer reads zero.
// Assumes: WAIT_CYC >= PRE_CYC + 2, LEAD_CYC >= 1, HOLD_CYC in 2..3.
module seq_fsm
    import cold_rst_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int LEAD_CYC = 2,
    parameter int WAIT_CYC = 20,
    parameter int PRE_CYC  = 4,
    parameter int HOLD_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_t       state_q
);
    localparam int MID_CYC = WAIT_CYC - 1 - PRE_CYC;

    seq_state_t nxt;

    // Next-state choice from start level and timer expiry.
    always_comb begin
        nxt = state_q;
        if (!start_i) begin
            nxt = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:     nxt = ST_ASSERT;
                ST_ASSERT:   if (tmr_zero) nxt = ST_PWR_ON;
                ST_PWR_ON:   nxt = ST_WAIT;
                ST_WAIT:     if (tmr_zero) nxt = ST_PRE_REL;
                ST_PRE_REL:  if (tmr_zero) nxt = ST_REL_HOLD;
                ST_REL_HOLD: if (tmr_zero) nxt = ST_DONE;
                ST_DONE:     nxt = ST_DONE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // Timer reload value for the state being entered.
    always_comb begin
        tmr_load = (nxt != state_q);
        case (nxt)
            ST_ASSERT:   tmr_val = CNT_W'(LEAD_CYC - 1);
            ST_WAIT:     tmr_val = CNT_W'(MID_CYC - 1);
            ST_PRE_REL:  tmr_val = CNT_W'(PRE_CYC - 1);
            ST_REL_HOLD: tmr_val = CNT_W'(HOLD_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= nxt;
    end

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/cold_reset_seq.sv
// Cold reset sequence generator top. Orders processor reset, power-good,
// ratio pins and extra configuration pins with cycle-counted intervals.
// Assumes: start_i is synchronous to clk; WAIT_CYC covers the required
// millisecond at the reference clock frequency.
module cold_reset_seq
    import cold_rst_pkg::*;
#(
    parameter int RATIO_W  = 5,
    parameter int XCFG_W   = 8,
    parameter int CLK_KHZ  = 100000,
    parameter int WAIT_CYC = CLK_KHZ + 1,
    parameter int LEAD_CYC = 2,
    parameter int PRE_CYC  = 4,
    parameter int HOLD_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [XCFG_W-1:0]  xcfg_i,
    output logic               prst_n_o,
    output logic               pwr_ok_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               ratio_oe_o,
    output logic [XCFG_W-1:0]  xcfg_o,
    output logic               xcfg_oe_o,
    output logic               seq_done_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    seq_state_t       st;
    logic             tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val;

    seq_fsm #(
        .CNT_W(CNT_W), .LEAD_CYC(LEAD_CYC), .WAIT_CYC(WAIT_CYC),
        .PRE_CYC(PRE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmr_zero(tmr_zero),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .state_q(st)
    );

    seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    cfg_capture #(.RATIO_W(RATIO_W), .XCFG_W(XCFG_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .capture_en(st == ST_IDLE),
        .ratio_i(ratio_i), .xcfg_i(xcfg_i), .ratio_q(ratio_o), .xcfg_q(xcfg_o)
    );

    // Output decode from the registered state.
    always_comb begin
        prst_n_o   = (st == ST_REL_HOLD) || (st == ST_DONE);
        pwr_ok_o   = (st != ST_IDLE) && (st != ST_ASSERT);
        ratio_oe_o = (st != ST_DONE);
        xcfg_oe_o  = (st == ST_PRE_REL) || (st == ST_REL_HOLD);
        seq_done_o = (st == ST_DONE);
    end

    // Counts clocks from power-good rise for the interval check.
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok_o)
            gap_q <= '0;
        else if (!prst_n_o && gap_q != '1)
            gap_q <= gap_q + 1'b1;
    end

    // R2
    ratio_during_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n_o |-> ratio_oe_o);
    // R3
    pwr_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ok_o) |-> !prst_n_o);
    // R4
    interval_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prst_n_o) |-> (gap_q >= CNT_W'(WAIT_CYC - 1)));
    // R5
    cfg_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prst_n_o) |-> (xcfg_oe_o && $past(xcfg_oe_o)));
    // R9
    done_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> (prst_n_o && pwr_ok_o && !xcfg_oe_o));
endmodule

// File: tb/cold_reset_seq_test.sv
`timescale 1ns/1ps
module cold_reset_seq_test;
    localparam int RW = 5, XW = 8;
    localparam int LEAD = 2, WAITC = 20, PRE = 4, HOLD = 3;
    localparam int K_PWR = LEAD + 1;
    localparam int K_REL = K_PWR + WAITC;
    localparam int K_CFG = K_REL - PRE;
    localparam int K_END = K_REL + HOLD;

    logic clk = 0, rst_n = 0, start_i = 0;
    logic [RW-1:0] ratio_i = '0;
    logic [XW-1:0] xcfg_i = '0;
    logic prst_n_o, pwr_ok_o, ratio_oe_o, xcfg_oe_o, seq_done_o;
    logic [RW-1:0] ratio_o;
    logic [XW-1:0] xcfg_o;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cold_reset_seq #(.RATIO_W(RW), .XCFG_W(XW), .WAIT_CYC(WAITC),
        .LEAD_CYC(LEAD), .PRE_CYC(PRE), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ratio_i(ratio_i),
        .xcfg_i(xcfg_i), .prst_n_o(prst_n_o), .pwr_ok_o(pwr_ok_o),
        .ratio_o(ratio_o), .ratio_oe_o(ratio_oe_o), .xcfg_o(xcfg_o),
        .xcfg_oe_o(xcfg_oe_o), .seq_done_o(seq_done_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(prst_n_o == 0, "R1 prst_n", prst_n_o, 0);
        chk(pwr_ok_o == 0, "R1 pwr_ok", pwr_ok_o, 0);
        chk(xcfg_oe_o == 0, "R1 xcfg_oe", xcfg_oe_o, 0);
        chk(seq_done_o == 0, "R1 done", seq_done_o, 0);
        chk(ratio_oe_o == 1, "R1 ratio_oe", ratio_oe_o, 1);
    endtask

    // Full sequence; inputs are disturbed mid-run (R7).
    task automatic test_full(input logic [RW-1:0] r, input logic [XW-1:0] c);
        int k_pwr = -1, k_rel = -1, k_cfg = -1, k_off = -1, k_done = -1;
        bit oe_ok = 1, r_ok = 1, c_ok = 1;
        @(negedge clk);
        ratio_i = r; xcfg_i = c; start_i = 1;
        for (int k = 1; k <= K_END + 5; k++) begin
            @(negedge clk);
            if (k == 6) begin ratio_i = ~r; xcfg_i = ~c; end
            if (pwr_ok_o && k_pwr < 0) begin
                k_pwr = k;
                chk(prst_n_o == 0, "R3 reset held at pwr_ok rise", prst_n_o, 0);
            end
            if (xcfg_oe_o && k_cfg < 0) k_cfg = k;
            if (prst_n_o && k_rel < 0) k_rel = k;
            if (k_rel > 0 && !ratio_oe_o && k_off < 0) k_off = k;
            if (seq_done_o && k_done < 0) k_done = k;
            if (!prst_n_o && !ratio_oe_o) oe_ok = 0;
            if (ratio_o != r) r_ok = 0;
            if (xcfg_oe_o && xcfg_o != c) c_ok = 0;
        end
        chk(k_pwr == K_PWR, "R3 pwr_ok rise clock", k_pwr, K_PWR);
        chk(k_rel - k_pwr == WAITC, "R4 interval", k_rel - k_pwr, WAITC);
        chk(k_rel - k_cfg == PRE, "R5 cfg lead", k_rel - k_cfg, PRE);
        chk(k_off - k_rel == HOLD, "R6 hold", k_off - k_rel, HOLD);
        chk(k_done == k_off, "R6 done with release", k_done, k_off);
        chk(xcfg_oe_o == 0, "R6 xcfg_oe dropped", xcfg_oe_o, 0);
        chk(oe_ok, "R2 ratio driven during reset", oe_ok, 1);
        chk(r_ok, "R2 R7 ratio held", ratio_o, r);
        chk(c_ok, "R5 R7 cfg held", xcfg_o, c);
        chk(seq_done_o && prst_n_o && pwr_ok_o, "R9 done held",
            {seq_done_o, prst_n_o, pwr_ok_o}, 7);
    endtask

    // Abort in the middle of the wait, then restart (R8).
    task automatic test_abort();
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        chk(!prst_n_o && !pwr_ok_o && !seq_done_o, "R8 after done drop",
            {prst_n_o, pwr_ok_o, seq_done_o}, 0);
        start_i = 1; ratio_i = 5'h0A; xcfg_i = 8'h3C;
        for (int k = 0; k < K_PWR + 5; k++) @(negedge clk);
        chk(pwr_ok_o == 1, "R8 mid wait pwr_ok", pwr_ok_o, 1);
        start_i = 0;
        @(negedge clk);
        chk(prst_n_o == 0 && pwr_ok_o == 0, "R8 abort reset/pwr",
            {prst_n_o, pwr_ok_o}, 0);
        chk(xcfg_oe_o == 0 && seq_done_o == 0, "R8 abort oe/done",
            {xcfg_oe_o, seq_done_o}, 0);
        chk(ratio_oe_o == 1, "R8 R2 ratio_oe in idle", ratio_oe_o, 1);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        test_reset();
        test_full(5'h13, 8'hA5);
        test_abort();
        test_full(5'h07, 8'h5A);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule